// File: doc/BRIEF.md
# Fast EPROM Programming Sequencer

This block writes a range of bytes into a UV-erasable EPROM with the pulse-and-verify fast algorithm. It fetches each target byte from a local buffer over a simple address/data read port. It drives the device address, data bus, chip-enable and output-enable strobes, and two select lines that ask an external supply stage for the raised programming levels. Every duration (supply settling, setup, pulse, hold, read access) comes from a clock-frequency parameter.

A run starts at address zero and ends at `last_addr`. The core supply is raised first and the programming supply second. Each address is first read back as a blank check. A target byte that needs a 0 turned into a 1 stops the run as un-programmable, since cells only move from 1 to 0. A byte that already holds its target is skipped. Any other byte receives timed program pulses, and each pulse is followed by a verify read. A match moves to the next address. After the pulse limit the run ends as a device failure. Once the range is done, the programming supply drops first and the core supply second, and every byte is read again at nominal levels. The run then finishes with pass, device-fail or un-programmable, together with the address involved.

Top module: `eprog_seq`

## Requirements
- R1: After reset and whenever idle, `rom_ce_n` and `rom_oe_n` are high, both supply selects are low, `busy` and `done` are low and `result` is 0.
- R2: `vpp_prog_sel` is high only while `vcc_prog_sel` is high. The core select rises at least one settle interval before the programming select, and the programming select falls at least one settle interval before the core select.
- R3: While the programming supply is selected, `rom_ce_n` goes low only as a pulse of exactly PULSE_US*CLK_MHZ cycles. During the pulse `rom_oe_n` is high, `rom_dout_en` is high, and `rom_addr` and `rom_dout` do not change.
- R4: Address and driven data are stable for at least SETUP_US*CLK_MHZ cycles before each pulse starts, and the data stays driven for at least HOLD_US*CLK_MHZ cycles after it ends.
- R5: After each pulse the byte is read back with `rom_oe_n` low and `rom_ce_n` high. A match advances to the next address and a mismatch triggers another pulse.
- R6: If the byte still mismatches after the 25th pulse (MAX_PULSES), the run ends with `result` = 2 (device fail), `fail_addr` and `cur_addr` equal to that address, and `pulse_cnt` = 25.
- R7: Before pulsing, the current contents are read. If the target has a 1 in any bit where the contents hold a 0, the run ends with `result` = 3 (un-programmable) and that address, and the address receives no pulse.
- R8: An address whose contents already equal the target receives no pulse.
- R9: After the last address both selects return low, and every address from 0 to `last_addr` is read with `rom_ce_n` and `rom_oe_n` low. The first mismatch ends the run with `result` = 2 and that address. Otherwise `result` = 1 (pass). A run that failed earlier performs no such read-back.
- R10: `done` rises when a run ends and, together with `result`, holds until the next `start`. `start` is ignored while `busy` is high, and `pulse_cnt` counts the pulses applied at `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| last_addr | input | ADDR_W | Final address of the range, starting at 0 |
| buf_addr | output | ADDR_W | Read address into the source buffer |
| buf_data | input | DATA_W | Target byte at `buf_addr`, same cycle |
| rom_addr | output | ADDR_W | Device address |
| rom_dout | output | DATA_W | Data driven to the device |
| rom_dout_en | output | 1 | Enables the data drivers toward the device |
| rom_din | input | DATA_W | Data read from the device |
| rom_ce_n | output | 1 | Chip enable, also used as the program pulse |
| rom_oe_n | output | 1 | Output enable |
| vcc_prog_sel | output | 1 | Selects the raised core supply level |
| vpp_prog_sel | output | 1 | Selects the programming supply level |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until next start |
| result | output | 2 | 0 none, 1 pass, 2 device fail, 3 un-programmable |
| cur_addr | output | ADDR_W | Address being worked on |
| pulse_cnt | output | PCNT_W | Pulses applied at `cur_addr` |
| fail_addr | output | ADDR_W | Address that caused a failure |

## Verification
The bound checker watches the strobe rules on every cycle. It checks that the programming select never appears without the core select and that a pulse keeps output-enable high with the data driven. It also checks that address and data are frozen during a pulse, that every pulse has the exact length, that the pulse counter stays within its limit, and that an idle block is quiet and keeps its finished result. Only the bench's device model can show the algorithm's decisions: how many pulses a slow cell gets, where the limit stops a run, and that blank-check refusals and skips leave an address unpulsed. It also shows that a read-back mismatch at nominal supply is caught with the right address, and that the setup and hold windows around each pulse are met.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC_UP,
        ST_VPP_UP,
        ST_BLANK,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_VPP_DN,
        ST_VCC_DN,
        ST_RDBACK
    } eprog_state_e;

    localparam logic [1:0] RES_NONE    = 2'd0;
    localparam logic [1:0] RES_PASS    = 2'd1;
    localparam logic [1:0] RES_DEVFAIL = 2'd2;
    localparam logic [1:0] RES_UNPROG  = 2'd3;

endpackage

// File: rtl/eprog_tmr.sv
// Down counter: a load of N-1 makes zero appear N cycles later.
module eprog_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eprog_byte_chk.sv
// Compares device contents against a target byte.
module eprog_byte_chk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] tgt,
    output logic              same,
    output logic              blocked
);
    // a target 1 over a stored 0 can never be reached by programming
    assign same    = (cur == tgt);
    assign blocked = |(tgt & ~cur);
endmodule

// File: rtl/eprog_seq.sv
module eprog_seq
    import eprog_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_MHZ    = 125,
    parameter int PULSE_US   = 100,
    parameter int SETUP_US   = 1,
    parameter int HOLD_US    = 1,
    parameter int SUP_US     = 1,
    parameter int ACC_NS     = 250,
    parameter int MAX_PULSES = 25,
    parameter int PCNT_W     = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_dout,
    output logic              rom_dout_en,
    input  logic [DATA_W-1:0] rom_din,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              vcc_prog_sel,
    output logic              vpp_prog_sel,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [PCNT_W-1:0] pulse_cnt,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int SETUP_CYC = (SETUP_US * CLK_MHZ < 1) ? 1 : SETUP_US * CLK_MHZ;
    localparam int HOLD_CYC  = (HOLD_US * CLK_MHZ < 1) ? 1 : HOLD_US * CLK_MHZ;
    localparam int SUP_CYC   = (SUP_US * CLK_MHZ < 1) ? 1 : SUP_US * CLK_MHZ;
    localparam int READ_CYC  = (ACC_NS * CLK_MHZ + 999) / 1000 + 1;
    localparam int TMAX      = (PULSE_CYC > SUP_CYC) ? PULSE_CYC : SUP_CYC;
    localparam int TW        = $clog2(TMAX + 1);

    typedef struct packed {
        eprog_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [PCNT_W-1:0] pcnt;
        logic [DATA_W-1:0] dout;
        logic [1:0]        res;
        logic [ADDR_W-1:0] faddr;
        logic              done;
        logic              err;
        logic              vcc;
        logic              vpp;
        logic              ce_n;
        logic              oe_n;
        logic              doe;
    } seq_s;

    seq_s s_d, s_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    eprog_tmr #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    logic [DATA_W-1:0] cmp_tgt;
    logic              cmp_same, cmp_blocked;

    assign cmp_tgt = (s_q.st == ST_VERIFY) ? s_q.dout : buf_data;

    eprog_byte_chk #(.DATA_W(DATA_W)) u_cmp (
        .cur     (rom_din),
        .tgt     (cmp_tgt),
        .same    (cmp_same),
        .blocked (cmp_blocked)
    );

    logic at_last;
    assign at_last = (s_q.addr == last_addr);

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.addr  = '0;
                s_d.pcnt  = '0;
                s_d.res   = RES_NONE;
                s_d.faddr = '0;
                s_d.done  = 1'b0;
                s_d.err   = 1'b0;
                s_d.st    = ST_VCC_UP;
                tmr_load  = 1'b1;
                tmr_val   = TW'(SUP_CYC - 1);
            end
            ST_VCC_UP: if (tmr_zero) begin
                s_d.st   = ST_VPP_UP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SUP_CYC - 1);
            end
            ST_VPP_UP: if (tmr_zero) begin
                s_d.st   = ST_BLANK;
                tmr_load = 1'b1;
                tmr_val  = TW'(READ_CYC - 1);
            end
            ST_BLANK: if (tmr_zero) begin
                s_d.dout = buf_data;
                tmr_load = 1'b1;
                if (cmp_blocked) begin
                    s_d.res   = RES_UNPROG;
                    s_d.faddr = s_q.addr;
                    s_d.err   = 1'b1;
                    s_d.st    = ST_VPP_DN;
                    tmr_val   = TW'(SUP_CYC - 1);
                end else if (cmp_same) begin
                    if (at_last) begin
                        s_d.st  = ST_VPP_DN;
                        tmr_val = TW'(SUP_CYC - 1);
                    end else begin
                        s_d.addr = s_q.addr + 1'b1;
                        s_d.pcnt = '0;
                        tmr_val  = TW'(READ_CYC - 1);
                    end
                end else begin
                    s_d.st  = ST_SETUP;
                    tmr_val = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: if (tmr_zero) begin
                s_d.st   = ST_PULSE;
                s_d.pcnt = s_q.pcnt + 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC - 1);
            end
            ST_PULSE: if (tmr_zero) begin
                s_d.st   = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_zero) begin
                s_d.st   = ST_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = TW'(READ_CYC - 1);
            end
            ST_VERIFY: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (cmp_same) begin
                    if (at_last) begin
                        s_d.st  = ST_VPP_DN;
                        tmr_val = TW'(SUP_CYC - 1);
                    end else begin
                        s_d.addr = s_q.addr + 1'b1;
                        s_d.pcnt = '0;
                        s_d.st   = ST_BLANK;
                        tmr_val  = TW'(READ_CYC - 1);
                    end
                end else if (s_q.pcnt == PCNT_W'(MAX_PULSES)) begin
                    s_d.res   = RES_DEVFAIL;
                    s_d.faddr = s_q.addr;
                    s_d.err   = 1'b1;
                    s_d.st    = ST_VPP_DN;
                    tmr_val   = TW'(SUP_CYC - 1);
                end else begin
                    s_d.st  = ST_SETUP;
                    tmr_val = TW'(SETUP_CYC - 1);
                end
            end
            ST_VPP_DN: if (tmr_zero) begin
                s_d.st   = ST_VCC_DN;
                tmr_load = 1'b1;
                tmr_val  = TW'(SUP_CYC - 1);
            end
            ST_VCC_DN: if (tmr_zero) begin
                if (s_q.err) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.addr = '0;
                    s_d.st   = ST_RDBACK;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(READ_CYC - 1);
                end
            end
            ST_RDBACK: if (tmr_zero) begin
                if (!cmp_same) begin
                    s_d.res   = RES_DEVFAIL;
                    s_d.faddr = s_q.addr;
                    s_d.st    = ST_IDLE;
                    s_d.done  = 1'b1;
                end else if (at_last) begin
                    s_d.res  = RES_PASS;
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(READ_CYC - 1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        // strobes and supply selects follow the state being entered
        s_d.vcc  = s_d.st inside {ST_VCC_UP, ST_VPP_UP, ST_BLANK, ST_SETUP,
                                  ST_PULSE, ST_HOLD, ST_VERIFY, ST_VPP_DN};
        s_d.vpp  = s_d.st inside {ST_VPP_UP, ST_BLANK, ST_SETUP, ST_PULSE,
                                  ST_HOLD, ST_VERIFY};
        s_d.ce_n = !(s_d.st inside {ST_PULSE, ST_RDBACK});
        s_d.oe_n = !(s_d.st inside {ST_BLANK, ST_VERIFY, ST_RDBACK});
        s_d.doe  = s_d.st inside {ST_SETUP, ST_PULSE, ST_HOLD};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.ce_n <= 1'b1;
            s_q.oe_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_addr     = s_q.addr;
    assign rom_addr     = s_q.addr;
    assign rom_dout     = s_q.dout;
    assign rom_dout_en  = s_q.doe;
    assign rom_ce_n     = s_q.ce_n;
    assign rom_oe_n     = s_q.oe_n;
    assign vcc_prog_sel = s_q.vcc;
    assign vpp_prog_sel = s_q.vpp;
    assign busy         = (s_q.st != ST_IDLE);
    assign done         = s_q.done;
    assign result       = s_q.res;
    assign cur_addr     = s_q.addr;
    assign pulse_cnt    = s_q.pcnt;
    assign fail_addr    = s_q.faddr;
endmodule

// File: rtl/eprog_seq_chk.sv
module eprog_seq_chk #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 12500,
    parameter int MAX_PULSES = 25,
    parameter int PCNT_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [DATA_W-1:0] rom_dout,
    input logic              rom_dout_en,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              vcc_prog_sel,
    input logic              vpp_prog_sel,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result,
    input logic [PCNT_W-1:0] pulse_cnt
);
    localparam int CW = $clog2(PULSE_CYC + 2);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt_q <= '0;
        else if (!rom_ce_n && vpp_prog_sel && low_cnt_q != {CW{1'b1}})
            low_cnt_q <= low_cnt_q + 1'b1;
        else if (rom_ce_n)
            low_cnt_q <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rom_ce_n && rom_oe_n && !vcc_prog_sel && !vpp_prog_sel));

    assert_supply_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_prog_sel |-> vcc_prog_sel);

    assert_pulse_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && vpp_prog_sel) |-> (rom_oe_n && rom_dout_en));

    assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && vpp_prog_sel && !$past(rom_ce_n))
            |-> ($stable(rom_addr) && $stable(rom_dout)));

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rom_ce_n) && vpp_prog_sel) |-> (low_cnt_q == CW'(PULSE_CYC)));

    assert_pulse_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= CW'(PULSE_CYC));

    assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PCNT_W'(MAX_PULSES));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));
endmodule

bind eprog_seq eprog_seq_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_US * CLK_MHZ),
    .MAX_PULSES (MAX_PULSES),
    .PCNT_W     (PCNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rom_addr     (rom_addr),
    .rom_dout     (rom_dout),
    .rom_dout_en  (rom_dout_en),
    .rom_ce_n     (rom_ce_n),
    .rom_oe_n     (rom_oe_n),
    .vcc_prog_sel (vcc_prog_sel),
    .vpp_prog_sel (vpp_prog_sel),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .pulse_cnt    (pulse_cnt)
);

// File: tb/eprog_seq_tb.sv
module eprog_seq_tb;
    localparam int AW      = 4;
    localparam int DW      = 8;
    localparam int MHZ     = 2;
    localparam int NB      = 1 << AW;
    localparam int PW      = 5;
    localparam int T_PULSE = 100 * MHZ;
    localparam int T_SETUP = 1 * MHZ;
    localparam int T_HOLD  = 1 * MHZ;
    localparam int LIMIT   = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_dout;
    logic          rom_dout_en;
    logic [DW-1:0] rom_din;
    logic          rom_ce_n, rom_oe_n, vcc_prog_sel, vpp_prog_sel;
    logic          busy, done;
    logic [1:0]    result;
    logic [AW-1:0] cur_addr, fail_addr;
    logic [PW-1:0] pulse_cnt;

    always #4 clk = ~clk;

    eprog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
        .buf_addr(buf_addr), .buf_data(buf_data),
        .rom_addr(rom_addr), .rom_dout(rom_dout), .rom_dout_en(rom_dout_en),
        .rom_din(rom_din), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .vcc_prog_sel(vcc_prog_sel), .vpp_prog_sel(vpp_prog_sel),
        .busy(busy), .done(done), .result(result), .cur_addr(cur_addr),
        .pulse_cnt(pulse_cnt), .fail_addr(fail_addr)
    );

    // device model and source buffer
    logic [DW-1:0] mem [NB];
    logic [DW-1:0] tgt [NB];
    int            need [NB];
    int            pulses [NB];
    int            inj_addr = -1;

    assign buf_data = tgt[buf_addr];
    assign rom_din  = !rom_oe_n
        ? (mem[rom_addr] ^ ((!vpp_prog_sel && !vcc_prog_sel && int'(rom_addr) == inj_addr) ? 8'h01 : 8'h00))
        : 8'hFF;

    always @(posedge rom_ce_n) begin
        if (vpp_prog_sel === 1'b1 && rom_oe_n === 1'b1 && rom_dout_en === 1'b1) begin
            pulses[rom_addr] = pulses[rom_addr] + 1;
            if (pulses[rom_addr] >= need[rom_addr])
                mem[rom_addr] = mem[rom_addr] & rom_dout;
        end
    end

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // protocol monitors
    int bad_width, bad_dc, bad_order, bad_setup, bad_hold;
    int low_run, setup_run, hold_run;
    logic hold_arm, prev_ce;
    logic [AW-1:0] prev_addr;
    logic [NB-1:0] rb_mask;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (!rom_ce_n && vpp_prog_sel) low_run++;
            else if (low_run != 0) begin
                if (low_run != T_PULSE) bad_width++;
                low_run = 0;
            end
            if (!rom_ce_n && !rom_oe_n && vpp_prog_sel) bad_dc++;
            if (vpp_prog_sel && !vcc_prog_sel) bad_order++;
            if (!rom_ce_n && prev_ce && vpp_prog_sel && setup_run < T_SETUP) bad_setup++;
            if (rom_dout_en && rom_ce_n && rom_addr == prev_addr) setup_run++;
            else if (!rom_dout_en || rom_addr != prev_addr) setup_run = 0;
            if (rom_ce_n && !prev_ce && vpp_prog_sel) begin
                hold_arm = 1'b1;
                hold_run = 0;
            end
            if (hold_arm) begin
                if (rom_dout_en) hold_run++;
                else begin
                    if (hold_run < T_HOLD) bad_hold++;
                    hold_arm = 1'b0;
                end
            end
            if (!rom_ce_n && !rom_oe_n && !vpp_prog_sel && !vcc_prog_sel)
                rb_mask[rom_addr] = 1'b1;
            prev_ce   = rom_ce_n;
            prev_addr = rom_addr;
        end
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < NB; i++) begin
            mem[i]    = 8'hFF;
            tgt[i]    = 8'((i * 29 + 3) ^ 8'h5A);
            need[i]   = 1;
            pulses[i] = 0;
        end
        inj_addr  = -1;
        bad_width = 0; bad_dc = 0; bad_order = 0; bad_setup = 0; bad_hold = 0;
        low_run = 0; setup_run = 0; hold_run = 0; hold_arm = 1'b0;
        prev_ce = 1'b1; prev_addr = '0; rb_mask = '0;
    endtask

    task automatic run(input int last);
        int w;
        last_addr = AW'(last);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        w = 0;
        while (!done && w < 40000) begin
            @(negedge clk);
            w++;
        end
        check("R10 run finished", int'(done), 1);
    endtask

    task automatic check_protocol(input string sfx);
        check({"R2 supply order ", sfx}, bad_order, 0);
        check({"R3 pulse width ", sfx}, bad_width, 0);
        check({"R3 no dc enable ", sfx}, bad_dc, 0);
        check({"R4 setup ", sfx}, bad_setup, 0);
        check({"R4 hold ", sfx}, bad_hold, 0);
        check({"R2 supplies off at end ", sfx}, int'(vcc_prog_sel) + int'(vpp_prog_sel), 0);
    endtask

    task automatic t_reset();
        check("R1 ce_n idle", int'(rom_ce_n), 1);
        check("R1 oe_n idle", int'(rom_oe_n), 1);
        check("R1 supplies idle", int'(vcc_prog_sel) + int'(vpp_prog_sel), 0);
        check("R1 busy/done idle", int'(busy) + int'(done), 0);
        check("R1 result idle", int'(result), 0);
    endtask

    task automatic t_basic();
        int ok;
        prep();
        run(7);
        check("R9 pass code", int'(result), 1);
        ok = 1;
        for (int i = 0; i < 8; i++) if (mem[i] != tgt[i]) ok = 0;
        check("R5 contents programmed", ok, 1);
        ok = 1;
        for (int i = 0; i < 8; i++) if (pulses[i] != ((tgt[i] != 8'hFF) ? 1 : 0)) ok = 0;
        check("R5 one pulse each", ok, 1);
        check("R9 readback covered all", int'(rb_mask[7:0]), 8'hFF);
        check("R9 readback range", int'(rb_mask[NB-1:8]), 0);
        check_protocol("basic");
    endtask

    task automatic t_retry();
        prep();
        need[3] = 5;
        need[1] = 3;
        last_addr = 4'd5;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        start = 1'b1;            // ignored while busy
        @(negedge clk); start = 1'b0;
        check("R10 still busy after extra start", int'(busy), 1);
        begin
            int w = 0;
            while (!done && w < 40000) begin @(negedge clk); w++; end
        end
        check("R9 retry pass", int'(result), 1);
        check("R5 slow byte 3 pulses", pulses[3], 5);
        check("R5 slow byte 1 pulses", pulses[1], 3);
        check("R10 extra start no double pulse", pulses[0], 1);
        check_protocol("retry");
    endtask

    task automatic t_limit();
        prep();
        need[2] = 100;
        run(5);
        check("R6 fail code", int'(result), 2);
        check("R6 fail addr", int'(fail_addr), 2);
        check("R6 cur addr", int'(cur_addr), 2);
        check("R6 pulses at limit", pulses[2], LIMIT);
        check("R6 pulse_cnt status", int'(pulse_cnt), LIMIT);
        check("R6 later byte untouched", pulses[3], 0);
        check("R9 no readback after fail", int'(rb_mask), 0);
        check_protocol("limit");
    endtask

    task automatic t_unprog();
        prep();
        mem[4] = 8'h00;
        tgt[4] = 8'h81;
        run(7);
        check("R7 unprog code", int'(result), 3);
        check("R7 fail addr", int'(fail_addr), 4);
        check("R7 no pulse at refused byte", pulses[4], 0);
        check("R7 earlier byte done", int'(mem[3]), int'(tgt[3]));
        check_protocol("unprog");
    endtask

    task automatic t_skip();
        prep();
        mem[2] = tgt[2];
        mem[3] = tgt[3] | 8'h0F;
        run(4);
        check("R8 pass code", int'(result), 1);
        check("R8 equal byte not pulsed", pulses[2], 0);
        check("R8 partial byte pulsed once", pulses[3], 1);
        check("R8 partial byte result", int'(mem[3]), int'(tgt[3]));
    endtask

    task automatic t_readback();
        prep();
        inj_addr = 5;
        run(7);
        check("R9 readback fail code", int'(result), 2);
        check("R9 readback fail addr", int'(fail_addr), 5);
        check("R9 readback stopped at fault", int'(rb_mask[7:0]), 8'h3F);
        check("R9 no extra pulses", pulses[5], 1);
        check_protocol("readback");
    endtask

    initial begin
        prep();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_retry();
        t_limit();
        t_unprog();
        t_skip();
        t_readback();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule